// File: doc/BRIEF.md
# Instruction-Cache Refill Coordinator

This block is the central tag controller of an instruction cache whose line data is spread across several independent data banks. It alone holds the tag and valid bit of every line. A lookup that matches a valid tag is answered in the same cycle, and the addressed block may be dispatched at once. On a miss the controller sends the line-aligned refill address to every bank as a single broadcast pulse. Each bank then fetches its own slice of the line, two 64-byte chunks, at its own pace.

Each bank reports back with a one-cycle completion pulse. The controller collects these pulses in a per-bank mask. It does not let the missed block dispatch, and it does not mark the line valid, until every bank has reported. Only one miss is handled at a time. While a miss is in progress the controller accepts no new lookups.

The cache is direct-mapped. An address splits, from least to most significant, into a line offset, a set index and a tag. With the default parameters the offset is 9 bits wide (4 banks × 2 chunks × 64 bytes), the index is 3 bits wide (8 sets), and the tag is the remaining 20 bits.

Top module: `icache_refill_ctrl`

## Requirements
- R1: Reset leaves every line invalid. After reset, `req_ready` is 1, `refill_valid` is 0 and `disp_ready` is 0, and the first lookup of any address misses.
- R2: A lookup whose tag matches the valid line at its index raises `hit` and `disp_ready` in the same cycle as `req_valid`. It starts no broadcast and leaves the controller ready in the next cycle.
- R3: A missed lookup is followed two cycles later by a one-cycle `refill_valid` pulse. `refill_addr` is the request address with its low 9 offset bits forced to zero.
- R4: Completion pulses on `bank_done` (bit i belongs to bank i) may arrive in any order, several in one cycle, and with any number of idle cycles between them. The completion mask is cleared in the broadcast cycle, so pulses seen in that cycle are not counted.
- R5: For a missed block, `disp_ready` is raised for exactly one cycle, namely the cycle after the clock edge at which the last outstanding bank's pulse was sampled. It is never raised earlier.
- R6: A repeated completion from a bank that has already reported has no effect. The other banks must still report.
- R7: Completion pulses that arrive while no miss is outstanding are ignored. They raise no output.
- R8: After a refill completes, a lookup of the same line hits at any offset. A lookup with a different tag at the same index misses and replaces that line.
- R9: From the cycle after a miss is accepted until the dispatch cycle, `req_ready` is 0, `hit` stays 0 whatever is on `req_valid`, and `refill_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W | Lookup byte address |
| req_ready | output | 1 | Controller is idle and takes lookups |
| hit | output | 1 | Lookup matched a valid line (same cycle) |
| disp_ready | output | 1 | The requested block may be dispatched |
| refill_valid | output | 1 | Refill broadcast pulse to all banks |
| refill_addr | output | ADDR_W | Line-aligned refill address |
| bank_done | input | NUM_BANKS | Per-bank refill completion pulses |

## Verification
The bench first sweeps every set with cold misses. Each miss uses a different completion order (forward or reverse rotations starting at each bank), a different spacing between pulses, and in one case all banks reporting together. These patterns show whether dispatch waits for the true last bank or only for some count of pulses. Some misses repeat a bank's pulse before the next bank reports, which separates a design that OR-accumulates completions from one that counts them. Others drive every completion bit in the broadcast cycle or while idle, which shows whether the mask is cleared at broadcast and whether stray pulses are ignored. Follow-up passes use several offsets and conflicting tags, which tells correct per-set tag storage apart from aliasing or lost valid bits.

// File: rtl/icache_refill_ctrl.sv
module icache_refill_ctrl #(
  parameter int NUM_BANKS       = 4,
  parameter int CHUNKS_PER_BANK = 2,
  parameter int CHUNK_BYTES     = 64,
  parameter int NUM_SETS        = 8,
  parameter int ADDR_W          = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 req_ready,
  output logic                 hit,
  output logic                 disp_ready,
  output logic                 refill_valid,
  output logic [ADDR_W-1:0]    refill_addr,
  input  logic [NUM_BANKS-1:0] bank_done
);
  localparam int OFF_W  = $clog2(NUM_BANKS * CHUNKS_PER_BANK * CHUNK_BYTES);
  localparam int IDX_W  = $clog2(NUM_SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = ADDR_W - OFF_W;

  typedef enum logic [2:0] {IDLE, LOOKUP, BROADCAST, WAIT_ALL, UPDATE_TAG} state_t;

  state_t               state;
  logic [TAG_W-1:0]     tag_mem [NUM_SETS];
  logic [NUM_SETS-1:0]  line_vld;
  logic [LINE_W-1:0]    miss_line;
  logic [NUM_BANKS-1:0] done_mask;

  wire [IDX_W-1:0]     req_idx   = req_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]     req_tag   = req_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0]     miss_idx  = miss_line[IDX_W-1:0];
  wire [TAG_W-1:0]     miss_tag  = miss_line[IDX_W +: TAG_W];
  wire [NUM_BANKS-1:0] done_next = done_mask | bank_done;
  wire                 is_idle   = (state == IDLE);
  wire                 tag_match = line_vld[req_idx] && (tag_mem[req_idx] == req_tag);
  wire                 unused_off = ^req_addr[OFF_W-1:0];

  assign req_ready    = is_idle;
  assign hit          = req_valid && is_idle && tag_match;
  assign disp_ready   = hit || (state == UPDATE_TAG);
  assign refill_valid = (state == BROADCAST);
  assign refill_addr  = {miss_line, {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= IDLE;
      line_vld  <= '0;
      miss_line <= '0;
      done_mask <= '0;
    end else begin
      case (state)
        IDLE: if (req_valid && !tag_match) begin
          miss_line <= req_addr[ADDR_W-1:OFF_W];
          state     <= LOOKUP;
        end
        LOOKUP: begin
          line_vld[miss_idx] <= 1'b0;
          state              <= BROADCAST;
        end
        BROADCAST: begin
          done_mask <= '0;
          state     <= WAIT_ALL;
        end
        WAIT_ALL: begin
          done_mask <= done_next;
          if (&done_next) state <= UPDATE_TAG;
        end
        UPDATE_TAG: begin
          line_vld[miss_idx] <= 1'b1;
          state              <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == UPDATE_TAG) tag_mem[miss_idx] <= miss_tag;
  end
endmodule

module icache_refill_ctrl_chk #(
  parameter int NUM_BANKS       = 4,
  parameter int CHUNKS_PER_BANK = 2,
  parameter int CHUNK_BYTES     = 64,
  parameter int ADDR_W          = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_ready,
  input logic                 hit,
  input logic                 disp_ready,
  input logic                 refill_valid,
  input logic [ADDR_W-1:0]    refill_addr,
  input logic [NUM_BANKS-1:0] bank_done
);
  localparam int OFF_W = $clog2(NUM_BANKS * CHUNKS_PER_BANK * CHUNK_BYTES);

  logic [NUM_BANKS-1:0] seen;
  always_ff @(posedge clk) begin
    if (!rst_n)            seen <= '0;
    else if (refill_valid) seen <= '0;
    else                   seen <= seen | bank_done;
  end

  AST_BCAST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid |=> !refill_valid); // R3
  AST_BCAST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid |-> (refill_addr[OFF_W-1:0] == '0)); // R3
  AST_HIT_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (disp_ready && req_ready && !refill_valid)); // R2
  AST_HIT_STAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (req_ready && !refill_valid)); // R2
  AST_DISP_AFTER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_ready && !hit) |-> (&seen)); // R5
  AST_DISP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_ready && !hit) |=> req_ready); // R5
  AST_BUSY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !hit); // R9
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(refill_addr)); // R9
endmodule

bind icache_refill_ctrl icache_refill_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS), .CHUNKS_PER_BANK(CHUNKS_PER_BANK),
  .CHUNK_BYTES(CHUNK_BYTES), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .hit(hit),
  .disp_ready(disp_ready), .refill_valid(refill_valid),
  .refill_addr(refill_addr), .bank_done(bank_done)
);

// File: tb/test_icache_refill_ctrl.sv
module test_icache_refill_ctrl;
  localparam int NB    = 4;
  localparam int SETS  = 8;
  localparam int AW    = 32;
  localparam int OFF_W = 9;
  localparam int IDX_W = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready, hit, disp_ready, refill_valid;
  logic [AW-1:0] refill_addr;
  logic [NB-1:0] bank_done = '0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] et [SETS];
  logic [SETS-1:0] ev = '0;

  always #5 clk = ~clk;

  icache_refill_ctrl #(.NUM_BANKS(NB), .NUM_SETS(SETS), .ADDR_W(AW)) i_icache_refill_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .hit(hit), .disp_ready(disp_ready),
    .refill_valid(refill_valid), .refill_addr(refill_addr), .bank_done(bank_done));

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int tag, input int idx, input int off);
    return 32'((tag << (OFF_W + IDX_W)) | (idx << OFF_W) | off);
  endfunction

  task automatic access(input logic [31:0] a, input string rh, input int step, input int seed,
                        input int gap, input bit dup, input bit all, input bit stray);
    int idx;
    logic [31:0] tag;
    bit exp_h;
    int prev;
    idx   = int'(a[OFF_W +: IDX_W]);
    tag   = a >> (OFF_W + IDX_W);
    exp_h = ev[idx] && (et[idx] == tag);
    prev  = 0;
    @(negedge clk); req_valid = 1'b1; req_addr = a; bank_done = '0; #1;
    chk(rh, 64'(hit), 64'(exp_h));
    chk(rh, 64'(disp_ready), 64'(exp_h));
    chk("R9", 64'(req_ready), 64'd1);
    if (exp_h) begin
      @(negedge clk); req_valid = 1'b0; #1;
      chk("R2", 64'(refill_valid), 64'd0);
      chk("R2", 64'(req_ready), 64'd1);
      return;
    end
    @(negedge clk); #1;
    chk("R9", 64'(req_ready), 64'd0);
    chk("R9", 64'(hit), 64'd0);
    chk("R3", 64'(refill_valid), 64'd0);
    @(negedge clk); req_valid = 1'b0; bank_done = stray ? '1 : '0; #1;
    chk("R3", 64'(refill_valid), 64'd1);
    chk("R3", 64'(refill_addr), 64'(a & ~32'h1FF));
    for (int k = 0; k < NB; k++) begin
      int b;
      b = (k * step + seed) % NB;
      repeat (gap) begin
        @(negedge clk); bank_done = '0; req_valid = 1'b1; #1;
        chk("R5", 64'(disp_ready), 64'd0);
        chk("R9", 64'(hit), 64'd0);
        chk("R3", 64'(refill_valid), 64'd0);
      end
      if (dup && k > 0) begin
        @(negedge clk); bank_done = 4'(1 << prev); req_valid = 1'b0; #1;
        chk("R6", 64'(disp_ready), 64'd0);
      end
      @(negedge clk); req_valid = 1'b0; bank_done = all ? '1 : 4'(1 << b); #1;
      chk("R4", 64'(disp_ready), 64'd0);
      prev = b;
      if (all) break;
    end
    @(negedge clk); bank_done = '0; #1;
    chk("R5", 64'(disp_ready), 64'd1);
    chk("R9", 64'(req_ready), 64'd0);
    chk("R9", 64'(refill_addr), 64'(a & ~32'h1FF));
    @(negedge clk); #1;
    chk("R5", 64'(disp_ready), 64'd0);
    chk("R9", 64'(req_ready), 64'd1);
    ev[idx] = 1'b1;
    et[idx] = tag;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    chk("R1", 64'(req_ready), 64'd1);
    chk("R1", 64'(refill_valid), 64'd0);
    chk("R1", 64'(disp_ready), 64'd0);
    chk("R1", 64'(hit), 64'd0);

    // R1 / R4 / R6: cold misses, all orders, spacings, duplicates, stray pulses at broadcast
    for (int i = 0; i < SETS; i++)
      access(mk(100 + 7 * i, i, i * 37), "R1", (i % 2 == 1) ? 3 : 1, i % NB, i % 3,
             (i % 3 == 1), (i == 5), (i % 2 == 0));

    // R8: hits at several offsets
    for (int i = 0; i < SETS; i++)
      for (int o = 0; o < 3; o++)
        access(mk(100 + 7 * i, i, (o == 0) ? 0 : (o == 1) ? 511 : 128), "R8", 1, 0, 0, 0, 0, 0);

    // R7: stray completions while idle
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); bank_done = 4'(4'hF >> c); req_valid = 1'b0; #1;
      chk("R7", 64'(disp_ready), 64'd0);
      chk("R7", 64'(refill_valid), 64'd0);
      chk("R7", 64'(req_ready), 64'd1);
    end
    @(negedge clk); bank_done = '0;

    // R8: conflicting tags replace even sets
    for (int i = 0; i < SETS; i += 2)
      access(mk(900 + i, i, 64), "R8", 3, (i + 1) % NB, 1, 1, 0, 1);
    for (int i = 0; i < SETS; i++)
      access(mk(100 + 7 * i, i, 3), "R8", 1, 2, 0, 0, 0, 0);
    for (int i = 0; i < SETS; i++)
      access(mk(900 + i, i, 200), "R8", 3, 3, 2, 0, (i == 3), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule